// File: doc/BRIEF.md
# UART Automatic Modem Handshake Controller

This block adds automatic request-to-send and clear-to-send handshaking to a UART. On the receive side it compares the receive FIFO occupancy with a programmable threshold, raises a threshold interrupt, and drives the RTS output with hysteresis. The output rises one table step above the selected threshold and falls one table step below it. On the transmit side it resynchronises the CTS input and flags a rising CTS edge as a flow-control request. It also withholds permission to transmit, but only at a character boundary.

The FIFO, shift registers and baud generator sit outside. They supply the FIFO count and two transmitter strobes: one for busy and one for the end of a character. The transmitter starts a new character only while `tx_allow` is high. When either automatic mode is off, that side of the block is transparent. RTS then follows its software bit and transmission stays permitted. Every output is registered.

Top module: `uart_autoflow`

## Requirements
- R1: After reset `rts_pin` is 0, `tx_allow` is 1, and both `rx_thresh_irq` and `cts_irq` are 0.
- R2: One cycle after a cycle in which `rts_auto_en` is 1, `rx_thresh_irq` equals (fifo_count >= L[trig_sel]). The threshold table L is indexed by `trig_sel` and defaults to 8, 16, 56, 60 for codes 0, 1, 2, 3. `rx_thresh_irq` is 0 one cycle after any cycle in which `rts_auto_en` is 0.
- R3: With automatic RTS on, `rts_pin` goes to 1 in the cycle after `fifo_count` reaches L[min(trig_sel+1,3)].
- R4: With automatic RTS on, a high `rts_pin` stays high until `fifo_count` drops below L[max(trig_sel-1,0)]. It goes to 0 in the cycle after that happens. Between the two levels the pin holds its value.
- R5: With automatic RTS off, `rts_pin` equals the value `rts_sw` had in the previous cycle.
- R6: A 0-to-1 change of `cts_pin` sets `cts_irq` three cycles later (two synchroniser stages plus the flag), but only if `cts_auto_en` and `cts_irq_en` are both 1. Otherwise the flag stays 0.
- R7: `cts_irq` stays set until a cycle with `irq_clr` high clears it. A new request in the same cycle as the clear wins, and the flag stays set.
- R8: When CTS asks for a stop while `tx_busy` is 1, `tx_allow` stays 1 until `char_done` pulses. It drops in the cycle after that pulse.
- R9: When CTS asks for a stop while `tx_busy` is 0, `tx_allow` drops three cycles after `cts_pin` rises.
- R10: `tx_allow` returns to 1 three cycles after `cts_pin` returns to 0.
- R11: With automatic CTS off, `tx_allow` stays 1 whatever `cts_pin` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_count | input | 7 | Receive FIFO occupancy (CNT_W bits) |
| trig_sel | input | 2 | Threshold table index |
| rts_auto_en | input | 1 | Automatic RTS enable |
| cts_auto_en | input | 1 | Automatic CTS enable |
| rts_sw | input | 1 | Software RTS value used when automation is off |
| cts_irq_en | input | 1 | Interrupt enable for the CTS request flag |
| irq_clr | input | 1 | One-cycle clear strobe for `cts_irq` |
| tx_busy | input | 1 | Transmitter is shifting a character |
| char_done | input | 1 | Stop bit of the current character has left |
| cts_pin | input | 1 | Asynchronous CTS input, 1 requests a stop |
| rts_pin | output | 1 | RTS output |
| tx_allow | output | 1 | Transmitter may begin a character |
| rx_thresh_irq | output | 1 | FIFO is at or above the selected threshold |
| cts_irq | output | 1 | Sticky CTS flow-control request flag |

## Verification
The bench builds the block with its default parameters: a 64-entry FIFO, thresholds of 8, 16, 56 and 60, and two synchroniser stages. With a two-stage synchroniser, the three-cycle CTS latency can be checked exactly. The 7-bit count reaches both ends of the threshold table, so the saturated neighbours at codes 0 and 3 are exercised along with the hysteresis band at code 1.

// File: rtl/uart_afc_pkg.sv
package uart_afc_pkg;
   localparam int NUM_LVL = 4;
   typedef logic [1:0] lvl_sel_t;

   // neighbour index above, saturating at the top of the table
   function automatic lvl_sel_t sel_up(lvl_sel_t s);
      return (s == lvl_sel_t'(NUM_LVL - 1)) ? s : s + 2'd1;
   endfunction

   // neighbour index below, saturating at the bottom of the table
   function automatic lvl_sel_t sel_dn(lvl_sel_t s);
      return (s == 2'd0) ? s : s - 2'd1;
   endfunction
endpackage

// File: rtl/afc_rx_ctrl.sv
module afc_rx_ctrl
   import uart_afc_pkg::*;
#(
   parameter int CNT_W = 7,
   parameter int TRIG_LVL [NUM_LVL] = '{8, 16, 56, 60}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] fifo_count,
   input  lvl_sel_t         trig_sel,
   input  logic             rts_auto_en,
   input  logic             rts_sw,
   output logic             rts_pin,
   output logic             rx_thresh_irq
);
   int   fill;
   logic at_thr, at_upper, below_lower;
   logic hold_q, hold_d;

   always_comb begin
      fill        = int'(fifo_count);
      at_thr      = fill >= TRIG_LVL[trig_sel];
      at_upper    = fill >= TRIG_LVL[sel_up(trig_sel)];
      below_lower = fill <  TRIG_LVL[sel_dn(trig_sel)];
      if (!rts_auto_en)     hold_d = 1'b0;
      else if (at_upper)    hold_d = 1'b1;
      else if (below_lower) hold_d = 1'b0;
      else                  hold_d = hold_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q        <= 1'b0;
         rts_pin       <= 1'b0;
         rx_thresh_irq <= 1'b0;
      end else begin
         hold_q        <= hold_d;
         rts_pin       <= rts_auto_en ? hold_d : rts_sw;
         rx_thresh_irq <= rts_auto_en & at_thr;
      end
   end
endmodule

// File: rtl/afc_cts_mon.sv
module afc_cts_mon #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cts_pin,
   input  logic cts_auto_en,
   input  logic cts_irq_en,
   input  logic irq_clr,
   output logic cts_sync,
   output logic cts_irq
);
   logic [STAGES:0] chain;
   logic            prev_q;
   logic            req_rise;

   assign chain[0] = cts_pin;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g+1] <= 1'b0;
            else        chain[g+1] <= chain[g];
         end
      end
   endgenerate

   assign cts_sync = chain[STAGES];
   assign req_rise = cts_sync & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         cts_irq <= 1'b0;
      end else begin
         prev_q <= cts_sync;
         if (req_rise && cts_auto_en && cts_irq_en) cts_irq <= 1'b1;
         else if (irq_clr)                          cts_irq <= 1'b0;
      end
   end
endmodule

// File: rtl/afc_tx_gate.sv
module afc_tx_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic cts_sync,
   input  logic cts_auto_en,
   input  logic tx_busy,
   input  logic char_done,
   output logic tx_allow
);
   logic mid_char;
   assign mid_char = tx_busy & ~char_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        tx_allow <= 1'b1;
      else if (!cts_auto_en || !cts_sync) tx_allow <= 1'b1;
      else                               tx_allow <= tx_allow & mid_char;
   end
endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
   import uart_afc_pkg::*;
#(
   parameter int FIFO_DEPTH  = 64,
   parameter int SYNC_STAGES = 2,
   parameter int TRIG_LVL [NUM_LVL] = '{8, 16, 56, 60},
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] fifo_count,
   input  logic [1:0]       trig_sel,
   input  logic             rts_auto_en,
   input  logic             cts_auto_en,
   input  logic             rts_sw,
   input  logic             cts_irq_en,
   input  logic             irq_clr,
   input  logic             tx_busy,
   input  logic             char_done,
   input  logic             cts_pin,
   output logic             rts_pin,
   output logic             tx_allow,
   output logic             rx_thresh_irq,
   output logic             cts_irq
);
   logic cts_sync;

   generate
      if (SYNC_STAGES < 2)
         $error("SYNC_STAGES must be at least 2");
      for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl_chk
         if (TRIG_LVL[k] < 1 || TRIG_LVL[k] > FIFO_DEPTH)
            $error("threshold outside FIFO range");
         if (k > 0) begin : g_ord
            if (TRIG_LVL[k] <= TRIG_LVL[k-1])
               $error("thresholds must ascend");
         end
      end
   endgenerate

   afc_rx_ctrl #(.CNT_W(CNT_W), .TRIG_LVL(TRIG_LVL)) u_rx (
      .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count),
      .trig_sel(lvl_sel_t'(trig_sel)), .rts_auto_en(rts_auto_en),
      .rts_sw(rts_sw), .rts_pin(rts_pin), .rx_thresh_irq(rx_thresh_irq)
   );

   afc_cts_mon #(.STAGES(SYNC_STAGES)) u_cts (
      .clk(clk), .rst_n(rst_n), .cts_pin(cts_pin),
      .cts_auto_en(cts_auto_en), .cts_irq_en(cts_irq_en),
      .irq_clr(irq_clr), .cts_sync(cts_sync), .cts_irq(cts_irq)
   );

   afc_tx_gate u_gate (
      .clk(clk), .rst_n(rst_n), .cts_sync(cts_sync),
      .cts_auto_en(cts_auto_en), .tx_busy(tx_busy),
      .char_done(char_done), .tx_allow(tx_allow)
   );
endmodule

// File: rtl/afc_chk.sv
module afc_chk
   import uart_afc_pkg::*;
#(
   parameter int CNT_W = 7,
   parameter int TRIG_LVL [NUM_LVL] = '{8, 16, 56, 60}
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] fifo_count,
   input logic             rts_auto_en,
   input logic             cts_auto_en,
   input logic             rts_sw,
   input logic             cts_irq_en,
   input logic             irq_clr,
   input logic             tx_busy,
   input logic             char_done,
   input logic             rts_pin,
   input logic             tx_allow,
   input logic             rx_thresh_irq,
   input logic             cts_irq
);
   // R3
   rts_rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rts_auto_en) && $rose(rts_pin)) |-> (int'($past(fifo_count)) >= TRIG_LVL[1]));
   // R4
   rts_fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rts_auto_en) && $fell(rts_pin)) |-> (int'($past(fifo_count)) < TRIG_LVL[NUM_LVL-2]));
   // R5
   rts_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rts_auto_en |=> (rts_pin == $past(rts_sw)));
   // R2
   thr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rts_auto_en |=> !rx_thresh_irq);
   // R6
   cts_flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cts_irq) |-> $past(cts_auto_en && cts_irq_en));
   // R7
   cts_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cts_irq && !irq_clr) |=> cts_irq);
   // R8
   tx_mid_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_allow && tx_busy && !char_done) |=> tx_allow);
   // R11
   tx_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cts_auto_en |=> tx_allow);
endmodule

bind uart_autoflow afc_chk #(.CNT_W(CNT_W), .TRIG_LVL(TRIG_LVL)) u_chk (
   .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count),
   .rts_auto_en(rts_auto_en), .cts_auto_en(cts_auto_en), .rts_sw(rts_sw),
   .cts_irq_en(cts_irq_en), .irq_clr(irq_clr), .tx_busy(tx_busy),
   .char_done(char_done), .rts_pin(rts_pin), .tx_allow(tx_allow),
   .rx_thresh_irq(rx_thresh_irq), .cts_irq(cts_irq)
);

// File: tb/sim_uart_autoflow.sv
module sim_uart_autoflow;
   localparam int PERIOD = 10;

   typedef struct {
      string    tag;
      logic [3:0] exp;   // {rts_pin, tx_allow, rx_thresh_irq, cts_irq}
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] fifo_count = '0;
   logic [1:0] trig_sel = '0;
   logic rts_auto_en = 0, cts_auto_en = 0, rts_sw = 0, cts_irq_en = 0;
   logic irq_clr = 0, tx_busy = 0, char_done = 0, cts_pin = 0;
   logic rts_pin, tx_allow, rx_thresh_irq, cts_irq;

   item_t sb[$];
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #(PERIOD/2) clk = ~clk;

   uart_autoflow u0 (
      .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count), .trig_sel(trig_sel),
      .rts_auto_en(rts_auto_en), .cts_auto_en(cts_auto_en), .rts_sw(rts_sw),
      .cts_irq_en(cts_irq_en), .irq_clr(irq_clr), .tx_busy(tx_busy),
      .char_done(char_done), .cts_pin(cts_pin), .rts_pin(rts_pin),
      .tx_allow(tx_allow), .rx_thresh_irq(rx_thresh_irq), .cts_irq(cts_irq)
   );

   // monitor: compares pending expectations mid-cycle
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         logic [3:0] act;
         it  = sb.pop_front();
         act = {rts_pin, tx_allow, rx_thresh_irq, cts_irq};
         n_chk++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: {rts,tx,rxi,ci} actual=%b expected=%b", it.tag, act, it.exp);
         end
      end
   end

   task automatic cyc(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect4(string tag, bit r, bit t, bit x, bit c);
      item_t it;
      it.tag = tag;
      it.exp = {r, t, x, c};
      sb.push_back(it);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(PERIOD * 5000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      cyc(2);
      rst_n = 1'b1;
      #1;
      expect4("R1 reset state", 0, 1, 0, 0);
      cyc(1);

      // manual RTS
      rts_sw = 1; cyc(1); expect4("R5 manual rts high", 1, 1, 0, 0);
      rts_sw = 0; cyc(1); expect4("R5 manual rts low", 0, 1, 0, 0);

      // automatic RTS, code 1: thr 16, up 56, down 8
      rts_auto_en = 1; trig_sel = 2'd1;
      fifo_count = 15; cyc(1); expect4("R2 below threshold", 0, 1, 0, 0);
      fifo_count = 16; cyc(1); expect4("R2 at threshold", 0, 1, 1, 0);
      fifo_count = 55; cyc(1); expect4("R3 one below upper", 0, 1, 1, 0);
      fifo_count = 56; cyc(1); expect4("R3 upper reached", 1, 1, 1, 0);
      fifo_count = 20; cyc(1); expect4("R4 hold in band", 1, 1, 1, 0);
      fifo_count = 8;  cyc(1); expect4("R4 hold at lower", 1, 1, 0, 0);
      fifo_count = 7;  cyc(1); expect4("R4 below lower", 0, 1, 0, 0);
      rts_sw = 1;      cyc(1); expect4("R5 sw ignored in auto", 0, 1, 0, 0);
      rts_sw = 0;

      // code 3: thr 60, up saturates at 60, down 56
      trig_sel = 2'd3;
      fifo_count = 59; cyc(1); expect4("R3 top below", 0, 1, 0, 0);
      fifo_count = 60; cyc(1); expect4("R3 top saturated", 1, 1, 1, 0);
      fifo_count = 56; cyc(1); expect4("R4 top hold", 1, 1, 0, 0);
      fifo_count = 55; cyc(1); expect4("R4 top release", 0, 1, 0, 0);

      // code 0: thr 8, up 16, down saturates at 8
      trig_sel = 2'd0;
      fifo_count = 16; cyc(1); expect4("R3 bottom upper", 1, 1, 1, 0);
      fifo_count = 8;  cyc(1); expect4("R4 bottom hold", 1, 1, 1, 0);
      fifo_count = 7;  cyc(1); expect4("R4 bottom release", 0, 1, 0, 0);

      // automation off again
      rts_auto_en = 0; fifo_count = 60;
      cyc(1); expect4("R2 irq off when disabled", 0, 1, 0, 0);
      rts_sw = 1; cyc(1); expect4("R5 back to manual", 1, 1, 0, 0);
      rts_sw = 0; fifo_count = 0; cyc(1);

      // CTS stop mid character
      cts_auto_en = 1; cts_irq_en = 1; tx_busy = 1;
      cts_pin = 1;
      cyc(2); expect4("R6 no early flag", 0, 1, 0, 0);
      cyc(1); expect4("R8 flag set, still sending", 0, 1, 0, 1);
      cyc(2); expect4("R8 waits for char end", 0, 1, 0, 1);
      char_done = 1; cyc(1); expect4("R8 stop after char end", 0, 0, 0, 1);
      char_done = 0; tx_busy = 0;
      cyc(1); expect4("R7 flag sticky", 0, 0, 0, 1);
      irq_clr = 1; cyc(1); expect4("R7 cleared", 0, 0, 0, 0);
      irq_clr = 0;
      cts_pin = 0;
      cyc(2); expect4("R10 not yet resumed", 0, 0, 0, 0);
      cyc(1); expect4("R10 resumed", 0, 1, 0, 0);

      // CTS stop while idle
      cts_pin = 1;
      cyc(3); expect4("R9 idle stop", 0, 0, 0, 1);
      cts_pin = 0; irq_clr = 1;
      cyc(1); irq_clr = 0;
      cyc(2); expect4("R10 idle resume", 0, 1, 0, 0);

      // interrupt enable off
      cts_irq_en = 0; cts_pin = 1;
      cyc(3); expect4("R6 masked flag", 0, 0, 0, 0);
      cts_pin = 0; cyc(3);

      // automatic CTS off
      cts_auto_en = 0; cts_irq_en = 1; cts_pin = 1;
      cyc(3); expect4("R11 ignored pin", 0, 1, 0, 0);
      cyc(2); expect4("R6 no flag when off", 0, 1, 0, 0);
      cts_pin = 0; cyc(3);

      // set beats clear
      cts_auto_en = 1; cts_pin = 1;
      cyc(2); irq_clr = 1;
      cyc(1); expect4("R7 set wins over clear", 0, 0, 0, 1);
      irq_clr = 0;
      cyc(1); expect4("R7 held after", 0, 0, 0, 1);
      irq_clr = 1; cyc(1); irq_clr = 0;
      expect4("R7 clear strobe", 0, 0, 0, 0);

      cyc(2);
      done = 1;
      report();
   end
endmodule